// File: doc/BRIEF.md
# Banked Data Address Mapper

This block sits between the data-side port of a small 8-bit microcontroller core and the storage and register space behind it. Every 8-bit data address the core presents is classified into one of six targets: banked general RAM, the underflow guard window, an unpopulated bank, a fixed-zero hole, the external peripheral port, or the sixteen-entry register file that occupies the top of the space. Reads return combinationally in the same cycle as the address; writes commit on the rising clock edge.

Only the lower half of the space (0x00–0x7F) is banked. The bank comes from the segment register, which is the top entry of the register file (0xFF). Accesses the core marks as stack accesses always land in bank 0, whatever the segment register holds. A configuration input turns banking off, and the segment register then becomes one more general-purpose register. In bank 0 the top sixteen bytes of the lower half return all-ones and cannot be written, so a stack that runs past its base reads an invalid pointer value. The number of implemented banks is a parameter. Segment values at or above it select a bank that cannot be written and reads as all-ones.

Top module: `bankmap_top`

## Requirements
- R1: Addresses 0x80–0xFF never depend on the segment register. A register or peripheral access yields the same location and data for every segment value.
- R2: With `cfg_bank_en` high and `cpu_stack` low, addresses 0x00–0x7F reach RAM in the bank numbered by the segment register (register-file entry 15, address 0xFF). Each bank keeps its own contents.
- R3: With `cpu_stack` high, an access to 0x00–0x7F uses bank 0 whatever the segment register holds.
- R4: In bank 0, reads of 0x70–0x7F return 0xFF. Writes there are discarded and change no RAM location in any bank.
- R5: Every implemented bank other than 0 stores all 128 bytes, 0x00–0x7F, including 0x70–0x7F.
- R6: Addresses 0xF0–0xFF read and write register-file entries 0–15, with the entry number equal to address bits [3:0]. Entries 12, 13, 14 and 15 are always visible on `reg_x`, `reg_sp`, `reg_b` and `reg_seg`.
- R7: With `cfg_bank_en` low, every non-stack access to 0x00–0x7F uses bank 0, and the segment register holds data like any other entry.
- R8: Reads of 0x80–0x8F and 0xE0–0xE8 return 0x00. Writes there are discarded, and `per_sel` and `per_wr` stay low.
- R9: For 0x90–0xDF and 0xE9–0xEF, `per_sel` is high and `per_addr` equals `cpu_addr`. `per_wr` follows `cpu_wr`, `per_wdata` follows `cpu_wdata`, and `cpu_rdata` returns `per_rdata`.
- R10: When the selected bank number is NUM_BANKS or greater, reads of 0x00–0x7F return 0xFF and writes are discarded. In particular, no implemented bank that shares the truncated index changes.
- R11: A synchronous active-high reset clears all sixteen register-file entries to 0x00. RAM is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_en | input | 1 | Banking enable for the lower half |
| cpu_addr | input | 8 | Data address from the core |
| cpu_stack | input | 1 | Marks the access as made through the stack pointer |
| cpu_wr | input | 1 | Write strobe, committed at the rising edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data |
| per_sel | output | 1 | Address falls in the peripheral window |
| per_addr | output | 8 | Address to the peripheral port |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data |
| reg_x | output | 8 | Register-file entry 12 (secondary pointer) |
| reg_sp | output | 8 | Register-file entry 13 (stack pointer) |
| reg_b | output | 8 | Register-file entry 14 (primary pointer) |
| reg_seg | output | 8 | Register-file entry 15 (segment) |

## Verification
The hardest case to expose from the ports is a discarded write into an unpopulated bank. With four banks, segment value 4 truncates to the same RAM index as bank 0, so a missing write gate shows up only as silent corruption of bank 0. The bench first plants a known byte at that bank-0 offset, selects bank 4, writes a different byte there, and then reads the offset back through bank 0. Stack isolation is checked the same way: a byte is planted in bank 2, a stack write is made to the same offset while the segment register still selects bank 2, and the planted byte must be unchanged afterwards.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int DATA_W   = 8;
    localparam int RF_DEPTH = 16;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t GUARD_LO  = 8'h70;
    localparam byte_t HOLE_A_HI = 8'h8F;
    localparam byte_t HOLE_B_LO = 8'hE0;
    localparam byte_t HOLE_B_HI = 8'hE8;
    localparam byte_t RF_LO     = 8'hF0;
    localparam byte_t ALL_ONES  = 8'hFF;

    localparam int IDX_X   = 12;
    localparam int IDX_SP  = 13;
    localparam int IDX_B   = 14;
    localparam int IDX_SEG = 15;

    typedef enum logic [2:0] {
        TGT_RAM,
        TGT_GUARD,
        TGT_VOID,
        TGT_ZERO,
        TGT_PERIPH,
        TGT_REGS
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        byte_t      bank;
        logic [6:0] offs;
        logic [3:0] ridx;
    } route_t;

    function automatic tgt_e classify_upper(input byte_t a);
        if (a >= RF_LO)                         return TGT_REGS;
        if (a <= HOLE_A_HI)                     return TGT_ZERO;
        if (a >= HOLE_B_LO && a <= HOLE_B_HI)   return TGT_ZERO;
        return TGT_PERIPH;
    endfunction

endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
    import bankmap_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  byte_t  addr,
    input  logic   stack,
    input  logic   bank_en,
    input  byte_t  seg,
    output route_t route
);

    always_comb begin
        route      = '0;
        route.offs = addr[6:0];
        route.ridx = addr[3:0];
        if (!addr[7]) begin
            route.bank = (stack || !bank_en) ? '0 : seg;
            if (route.bank == '0 && addr >= GUARD_LO)
                route.tgt = TGT_GUARD;
            else if (int'(route.bank) >= NUM_BANKS)
                route.tgt = TGT_VOID;
            else
                route.tgt = TGT_RAM;
        end else begin
            route.tgt = classify_upper(addr);
        end
    end

endmodule

// File: rtl/bankmap_regfile.sv
module bankmap_regfile
    import bankmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [3:0] idx,
    input  byte_t      wdata,
    output byte_t      rdata,
    output byte_t      r_x,
    output byte_t      r_sp,
    output byte_t      r_b,
    output byte_t      r_seg
);

    byte_t regs [RF_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_DEPTH; i++) regs[i] <= '0;
        end else if (we) begin
            regs[idx] <= wdata;
        end
    end

    assign rdata = regs[idx];
    assign r_x   = regs[IDX_X];
    assign r_sp  = regs[IDX_SP];
    assign r_b   = regs[IDX_B];
    assign r_seg = regs[IDX_SEG];

endmodule

// File: rtl/bankmap_ram.sv
module bankmap_ram
    import bankmap_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic       clk,
    input  logic       we,
    input  byte_t      bank,
    input  logic [6:0] offs,
    input  byte_t      wdata,
    output byte_t      rdata
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int IDX_W  = BANK_W + 7;
    localparam int DEPTH  = NUM_BANKS * 128;

    byte_t             mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic [BANK_W-1:0] bsel;

    assign bsel = BANK_W'(bank);
    assign idx  = {bsel, offs};

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
    import bankmap_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_bank_en,
    input  logic [7:0] cpu_addr,
    input  logic       cpu_stack,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       per_sel,
    output logic [7:0] per_addr,
    output logic       per_wr,
    output logic [7:0] per_wdata,
    input  logic [7:0] per_rdata,
    output logic [7:0] reg_x,
    output logic [7:0] reg_sp,
    output logic [7:0] reg_b,
    output logic [7:0] reg_seg
);

    route_t route;
    byte_t  ram_rd, rf_rd;
    logic   ram_we, rf_we;

    bankmap_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .addr    (cpu_addr),
        .stack   (cpu_stack),
        .bank_en (cfg_bank_en),
        .seg     (reg_seg),
        .route   (route)
    );

    assign ram_we = cpu_wr && (route.tgt == TGT_RAM);
    assign rf_we  = cpu_wr && (route.tgt == TGT_REGS);

    bankmap_ram #(.NUM_BANKS(NUM_BANKS)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .bank  (route.bank),
        .offs  (route.offs),
        .wdata (cpu_wdata),
        .rdata (ram_rd)
    );

    bankmap_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .idx   (route.ridx),
        .wdata (cpu_wdata),
        .rdata (rf_rd),
        .r_x   (reg_x),
        .r_sp  (reg_sp),
        .r_b   (reg_b),
        .r_seg (reg_seg)
    );

    assign per_sel   = (route.tgt == TGT_PERIPH);
    assign per_addr  = cpu_addr;
    assign per_wr    = cpu_wr && per_sel;
    assign per_wdata = cpu_wdata;

    always_comb begin
        unique case (route.tgt)
            TGT_RAM:    cpu_rdata = ram_rd;
            TGT_REGS:   cpu_rdata = rf_rd;
            TGT_PERIPH: cpu_rdata = per_rdata;
            TGT_ZERO:   cpu_rdata = '0;
            default:    cpu_rdata = ALL_ONES;
        endcase
    end

endmodule

// File: rtl/bankmap_chk.sv
module bankmap_chk
    import bankmap_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cfg_bank_en,
    input logic [7:0] cpu_addr,
    input logic       cpu_stack,
    input logic       cpu_wr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic       per_sel,
    input logic       per_wr,
    input logic [7:0] per_rdata,
    input logic [7:0] reg_x,
    input logic [7:0] reg_sp,
    input logic [7:0] reg_b,
    input logic [7:0] reg_seg,
    input logic       ram_we,
    input route_t     route
);

    p_upper_unbanked_r1: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[7] |-> !ram_we);

    p_bank_follows_seg_r2: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[7] && !cpu_stack && cfg_bank_en && ram_we) |-> route.bank == reg_seg);

    p_stack_bank0_r3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[7] && cpu_stack) |-> route.bank == 8'h00);

    p_guard_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= 8'h70 && cpu_addr <= 8'h7F && (cpu_stack || !cfg_bank_en || reg_seg == 8'h00))
        |-> (cpu_rdata == 8'hFF && !ram_we));

    p_seg_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 8'hFF) |=> reg_seg == $past(cpu_wdata));

    p_nobank_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bank_en && !cpu_addr[7]) |-> route.bank == 8'h00);

    p_hole_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ((cpu_addr >= 8'h80 && cpu_addr <= 8'h8F) || (cpu_addr >= 8'hE0 && cpu_addr <= 8'hE8))
        |-> (cpu_rdata == 8'h00 && !per_sel && !per_wr));

    p_periph_data_r9: assert property (@(posedge clk) disable iff (rst)
        per_sel |-> (cpu_rdata == per_rdata && per_wr == cpu_wr));

    p_void_bank_r10: assert property (@(posedge clk) disable iff (rst)
        (!cpu_addr[7] && !cpu_stack && cfg_bank_en && int'(reg_seg) >= NUM_BANKS)
        |-> (cpu_rdata == 8'hFF && !ram_we));

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (reg_x == 8'h00 && reg_sp == 8'h00 && reg_b == 8'h00 && reg_seg == 8'h00));

endmodule

bind bankmap_top bankmap_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_bank_en (cfg_bank_en),
    .cpu_addr    (cpu_addr),
    .cpu_stack   (cpu_stack),
    .cpu_wr      (cpu_wr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rdata   (cpu_rdata),
    .per_sel     (per_sel),
    .per_wr      (per_wr),
    .per_rdata   (per_rdata),
    .reg_x       (reg_x),
    .reg_sp      (reg_sp),
    .reg_b       (reg_b),
    .reg_seg     (reg_seg),
    .ram_we      (ram_we),
    .route       (route)
);

// File: tb/tb_bankmap_top.sv
module tb_bankmap_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_bank_en = 1'b1;
    logic [7:0] cpu_addr = 8'h00;
    logic       cpu_stack = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       per_sel;
    logic [7:0] per_addr;
    logic       per_wr;
    logic [7:0] per_wdata;
    logic [7:0] per_rdata = 8'h5A;
    logic [7:0] reg_x, reg_sp, reg_b, reg_seg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bankmap_top #(.NUM_BANKS(4)) dut (
        .clk(clk), .rst(rst), .cfg_bank_en(cfg_bank_en),
        .cpu_addr(cpu_addr), .cpu_stack(cpu_stack), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .per_sel(per_sel), .per_addr(per_addr), .per_wr(per_wr),
        .per_wdata(per_wdata), .per_rdata(per_rdata),
        .reg_x(reg_x), .reg_sp(reg_sp), .reg_b(reg_b), .reg_seg(reg_seg)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stk);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_stack = stk; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_stack = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic stk, input logic [7:0] exp);
        @(negedge clk);
        cpu_addr = a; cpu_stack = stk; cpu_wr = 1'b0;
        #1;
        check(req, cpu_rdata, exp);
        cpu_stack = 1'b0;
    endtask

    task automatic set_seg(input logic [7:0] s);
        wr(8'hFF, s, 1'b0);
    endtask

    task automatic t_reset;
        check("R11 reg_x", reg_x, 8'h00);
        check("R11 reg_sp", reg_sp, 8'h00);
        check("R11 reg_b", reg_b, 8'h00);
        check("R11 reg_seg", reg_seg, 8'h00);
        rd("R11 entry 5", 8'hF5, 1'b0, 8'h00);
    endtask

    task automatic t_banked;
        set_seg(8'd1); wr(8'h10, 8'hA1, 1'b0);
        set_seg(8'd2); wr(8'h10, 8'hA2, 1'b0);
        set_seg(8'd0); wr(8'h10, 8'hA0, 1'b0);
        set_seg(8'd1); rd("R2 bank1", 8'h10, 1'b0, 8'hA1);
        set_seg(8'd2); rd("R2 bank2", 8'h10, 1'b0, 8'hA2);
        set_seg(8'd0); rd("R2 bank0", 8'h10, 1'b0, 8'hA0);
    endtask

    task automatic t_stack;
        set_seg(8'd2); wr(8'h20, 8'h44, 1'b0);
        wr(8'h20, 8'h33, 1'b1);
        rd("R3 stack read", 8'h20, 1'b1, 8'h33);
        rd("R3 bank2 untouched", 8'h20, 1'b0, 8'h44);
        set_seg(8'd0);
        rd("R3 stack data in bank0", 8'h20, 1'b0, 8'h33);
    endtask

    task automatic t_guard;
        set_seg(8'd3); wr(8'h70, 8'h70, 1'b0);
        set_seg(8'd0); wr(8'h70, 8'h12, 1'b0);
        rd("R4 guard 0x70", 8'h70, 1'b0, 8'hFF);
        set_seg(8'd2);
        rd("R4 guard via stack 0x7F", 8'h7F, 1'b1, 8'hFF);
        set_seg(8'd3);
        rd("R4 no alias to bank3", 8'h70, 1'b0, 8'h70);
    endtask

    task automatic t_full;
        set_seg(8'd3);
        wr(8'h7F, 8'h77, 1'b0);
        wr(8'h00, 8'h01, 1'b0);
        rd("R5 bank3 0x7F", 8'h7F, 1'b0, 8'h77);
        rd("R5 bank3 0x70", 8'h70, 1'b0, 8'h70);
        rd("R5 bank3 0x00", 8'h00, 1'b0, 8'h01);
    endtask

    task automatic t_void;
        set_seg(8'd0); wr(8'h30, 8'h66, 1'b0);
        set_seg(8'd4); wr(8'h30, 8'h55, 1'b0);
        rd("R10 bank4 read", 8'h30, 1'b0, 8'hFF);
        set_seg(8'd5);
        rd("R10 bank5 read", 8'h30, 1'b0, 8'hFF);
        set_seg(8'd0);
        rd("R10 bank0 not aliased", 8'h30, 1'b0, 8'h66);
    endtask

    task automatic t_regs;
        wr(8'hFC, 8'h1C, 1'b0);
        wr(8'hFD, 8'h6F, 1'b0);
        wr(8'hFE, 8'h2E, 1'b0);
        wr(8'hF0, 8'hC0, 1'b0);
        set_seg(8'd1);
        check("R6 reg_x", reg_x, 8'h1C);
        check("R6 reg_sp", reg_sp, 8'h6F);
        check("R6 reg_b", reg_b, 8'h2E);
        check("R6 reg_seg", reg_seg, 8'h01);
        rd("R6 entry 0", 8'hF0, 1'b0, 8'hC0);
        rd("R6 entry 13", 8'hFD, 1'b0, 8'h6F);
    endtask

    task automatic t_upper;
        set_seg(8'd2); wr(8'hF3, 8'h3C, 1'b0);
        set_seg(8'd1); rd("R1 entry 3 any seg", 8'hF3, 1'b0, 8'h3C);
        set_seg(8'd6); rd("R1 entry 3 void seg", 8'hF3, 1'b0, 8'h3C);
        rd("R1 periph with void seg", 8'hA0, 1'b0, 8'h5A);
        set_seg(8'd1);
    endtask

    task automatic t_nobank;
        set_seg(8'd3);
        @(negedge clk); cfg_bank_en = 1'b0;
        wr(8'h10, 8'hB0, 1'b0);
        rd("R7 reads bank0", 8'h10, 1'b0, 8'hB0);
        rd("R7 guard stays", 8'h75, 1'b0, 8'hFF);
        check("R7 seg as plain reg", reg_seg, 8'h03);
        @(negedge clk); cfg_bank_en = 1'b1;
        set_seg(8'd0);
        rd("R7 write landed in bank0", 8'h10, 1'b0, 8'hB0);
        set_seg(8'd3);
        rd("R7 bank3 untouched", 8'h7F, 1'b0, 8'h77);
    endtask

    task automatic t_holes;
        logic [7:0] addrs [4] = '{8'h80, 8'h8F, 8'hE0, 8'hE8};
        per_rdata = 8'h5A;
        for (int i = 0; i < 4; i++) begin
            rd("R8 hole read", addrs[i], 1'b0, 8'h00);
            check("R8 per_sel low", {7'd0, per_sel}, 8'h00);
        end
        @(negedge clk);
        cpu_addr = 8'h85; cpu_wdata = 8'hEE; cpu_wr = 1'b1;
        #1;
        check("R8 per_wr low on hole write", {7'd0, per_wr}, 8'h00);
        @(negedge clk); cpu_wr = 1'b0;
        rd("R8 hole after write", 8'h85, 1'b0, 8'h00);
    endtask

    task automatic t_periph;
        logic [7:0] addrs [4] = '{8'h90, 8'hDF, 8'hE9, 8'hEF};
        for (int i = 0; i < 4; i++) begin
            per_rdata = 8'h30 + 8'(i);
            rd("R9 periph read", addrs[i], 1'b0, 8'h30 + 8'(i));
            check("R9 per_sel", {7'd0, per_sel}, 8'h01);
            check("R9 per_addr", per_addr, addrs[i]);
        end
        @(negedge clk);
        cpu_addr = 8'hC4; cpu_wdata = 8'h9D; cpu_wr = 1'b1;
        #1;
        check("R9 per_wr", {7'd0, per_wr}, 8'h01);
        check("R9 per_wdata", per_wdata, 8'h9D);
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_banked();
        t_stack();
        t_guard();
        t_full();
        t_void();
        t_regs();
        t_upper();
        t_nobank();
        t_holes();
        t_periph();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule